// File: doc/BRIEF.md
# Sticky Overflow Interrupt Status Bank

This block gathers single-cycle overflow events from ten counters and FIFOs into one 16-bit status word. A bit is latched at a fixed position when its event pulses. It stays latched until software clears it by writing a zero to that position. A second 16-bit word holds one enable bit per status bit. The block drives a single registered interrupt that is high while any enabled status bit is set.

Software reaches both words through a simple port in the system clock domain. The read mux is combinational. Writes take effect on the next rising clock edge. Reading never changes any state. Positions that carry no source always read as zero and never store anything.

Top module: `ovf_irq_bank`

## Requirements
- R1: After reset, the status word, the enable word and `irq` are all zero.
- R2: A one on `src[k]` at a rising edge sets one status bit, which is visible from that edge on. The mapping is: src[0..2] set bits 1..3, src[3] sets bit 5, src[4] sets bit 7, src[5..8] set bits 8..11, and src[9] sets bit 12.
- R3: A set status bit stays set across any number of cycles and reads (`rd_sel`=0), until it is explicitly cleared.
- R4: A write with `wr_sel`=0 clears each status bit whose `wr_data` bit is 0. Status bits whose `wr_data` bit is 1 keep their value, and a 1 never sets a bit.
- R5: If a source pulse and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R6: Bit positions 0, 4, 6 and 13 to 15 of both words always read 0, and writes to them are ignored.
- R7: `irq` equals the OR of (status AND enable) as it stood after the previous edge, so it lags the status and enable words by exactly one cycle.
- R8: A write with `wr_sel`=1 loads the enable word from `wr_data` (valid positions only). A read with `rd_sel`=1 returns it, and status writes leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 10 | Overflow event pulses, one per source |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 status (clear-by-zero), 1 enable |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 enable |
| rd_data | output | 16 | Selected word, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check four things: a set status bit survives unless a zero is written over it, a pulse always lands in the status word, no bit rises without a pulse, and unused positions stay zero. They also check that `irq` tracks the enabled status with one cycle of lag. The bench scenarios show the things a property cannot see. These are the exact source-to-position map, the readback values of both words, and the result of a pulse racing a clearing write. They also show that a status write leaves the enable word alone.

// File: rtl/ovf_irq_bank.sv
module ovf_irq_bank #(
  parameter int NSRC = 10,
  parameter int W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [W-1:0]    wr_data,
  input  logic            rd_sel,
  output logic [W-1:0]    rd_data,
  output logic            irq
);
  localparam logic [W-1:0] VALID = W'(16'h1FAE);

  logic [W-1:0] st_q, en_q, ev, keep;

  assign ev = {3'b000, src[9], src[8:5], src[4], 1'b0, src[3], 1'b0, src[2:0], 1'b0};
  assign keep = (wr_en && !wr_sel) ? wr_data : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= ((st_q & keep) | ev) & VALID;
      if (wr_en && wr_sel) en_q <= wr_data & VALID;
      irq  <= |(st_q & en_q);
    end
  end

  assign rd_data = rd_sel ? en_q : st_q;

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(st_q & keep)) == $past(st_q & keep)));
  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((st_q & $past(ev)) == $past(ev)));
  p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(ev)) == '0));
  p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q | en_q) & ~VALID) == '0);
  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == $past(|(st_q & en_q))));
endmodule

// File: tb/ovf_irq_bank_tb.sv
module ovf_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  src = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  int n_run = 0, n_fail = 0;

  localparam logic [15:0] POS [10] = '{16'h0002, 16'h0004, 16'h0008, 16'h0020, 16'h0080,
                                       16'h0100, 16'h0200, 16'h0400, 16'h0800, 16'h1000};

  always #2.5 clk = ~clk;

  ovf_irq_bank u_dut (.clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .wr_sel(wr_sel),
                      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(bit sel, string tag, logic [15:0] exp);
    rd_sel = sel; #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(bit sel, logic [15:0] d, logic [9:0] s = '0);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; src = s;
    tick();
    wr_en = 1'b0; src = '0;
  endtask

  task automatic pulse(logic [9:0] s);
    src = s; tick(); src = '0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rd(0, "R1 status after reset", 16'h0000);
    rd(1, "R1 enable after reset", 16'h0000);
    chk("R1 irq after reset", {15'b0, irq}, 16'h0000);
    rst_n = 1'b1; tick();

    for (int i = 0; i < 10; i++) begin
      pulse(10'(1) << i);
      rd(0, $sformatf("R2 src %0d position", i), POS[i]);
      wr(0, ~POS[i]);
      rd(0, $sformatf("R4 src %0d cleared", i), 16'h0000);
    end

    pulse(10'h200);
    for (int i = 0; i < 3; i++) begin rd(0, "R3 sticky under reads", 16'h1000); tick(); end
    wr(0, 16'hFFFF);
    rd(0, "R4 write ones keeps bit", 16'h1000);
    chk("R7 irq low while disabled", {15'b0, irq}, 16'h0000);

    wr(1, 16'h1000);
    rd(1, "R8 enable readback", 16'h1000);
    chk("R7 irq one cycle lag rise", {15'b0, irq}, 16'h0000);
    tick();
    chk("R7 irq asserted", {15'b0, irq}, 16'h0001);
    wr(0, 16'h0000);
    rd(0, "R4 clear all", 16'h0000);
    rd(1, "R8 enable untouched by status write", 16'h1000);
    chk("R7 irq one cycle lag fall", {15'b0, irq}, 16'h0001);
    tick();
    chk("R7 irq deasserted", {15'b0, irq}, 16'h0000);

    pulse(10'h200);
    wr(0, 16'h0000, 10'h001);
    rd(0, "R5 pulse wins over clear", 16'h0002);
    tick(); tick();
    chk("R7 irq off for unenabled bit", {15'b0, irq}, 16'h0000);
    wr(0, 16'h0000);

    wr(1, 16'hFFFF);
    rd(1, "R6 enable unused bits zero", 16'h1FAE);
    wr(0, 16'hFFFF);
    rd(0, "R6 ones do not set status", 16'h0000);
    pulse(10'h3FF);
    rd(0, "R6 all sources only valid bits", 16'h1FAE);
    wr(0, 16'h0051);
    rd(0, "R6 unused clear mask ignored", 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule